// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Control Logic

This block turns a single PWM level into two switch enables for a synchronous buck stage: one for the upper (high-side) switch and one for the lower (low-side) switch. Dead time is not fixed. Each switch turns on only after a comparator flag shows that the opposite switch is off. The flags are the switch node being low, the high-side drive being low, and the low-side drive being low. All flags arrive already synchronized to the clock.

If the switch node never collapses after the high-side turns off, for example because the upper switch is shorted, a cycle timer forces the low-side on anyway.

Three overrides are evaluated ahead of the output registers. A low on the shutdown input or on the supply-good flag turns both switches off. A low on the low-side disable input keeps only the lower switch off. A crowbar request forces the lower switch on and the upper switch off, and it outranks every other control. The block sits between a PWM controller and an analog gate-driver pair.

Top module: `nol_gate_ctrl`

## Requirements
- R1: `hs_en_o` and `ls_en_o` are never high in the same cycle.
- R2: On the edge that samples `pwm_i` high (with `crowbar_i` low), `ls_en_o` goes low. `hs_en_o` rises on the first edge that samples `ls_low_i` high while `pwm_i` is high and the block is enabled, and not before that edge.
- R3: On the edge that samples `pwm_i` low, `hs_en_o` goes low. `ls_en_o` rises on the first edge that samples `sw_low_i` and `hs_low_i` both high. One of the two flags alone does not turn it on.
- R4: If the two flags of R3 are never both true, `ls_en_o` rises exactly TO_CYC edges after the edge that dropped `hs_en_o`. TO_CYC = clamp(TIMEOUT_NS, 150, 600) * 1000 / CLK_PERIOD_PS. The defaults are 350 ns and 5000 ps, which gives 70.
- R5: If `pwm_i` rises again before the timeout expires, the timer is discarded. The next falling edge starts a full TO_CYC count.
- R6: With `shdn_ni` low and `crowbar_i` low, both enables are low from the next edge on, whatever `pwm_i` is. After release, the low-side turns on again only through R3 or R4.
- R7: With `supply_ok_i` low and `crowbar_i` low, both enables are low from the next edge on.
- R8: With `ls_dis_ni` low, `ls_en_o` is low from the next edge on, and `hs_en_o` is unaffected. With it high, the low side follows R2 to R4.
- R9: With `crowbar_i` high, the next edge gives `hs_en_o` = 0 and `ls_en_o` = 1. This holds regardless of shutdown, supply-good, the low-side disable, PWM and the flags.
- R10: During and right after reset, both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command; high requests the high-side switch |
| shdn_ni | input | 1 | Shutdown, active low; turns both switches off |
| ls_dis_ni | input | 1 | Low-side disable, active low |
| crowbar_i | input | 1 | Crowbar request; forces the low-side on |
| supply_ok_i | input | 1 | Supply-good flag; low means lockout |
| sw_low_i | input | 1 | Switch node below threshold |
| hs_low_i | input | 1 | High-side drive below threshold |
| ls_low_i | input | 1 | Low-side drive below threshold |
| hs_en_o | output | 1 | High-side switch enable (registered) |
| ls_en_o | output | 1 | Low-side switch enable (registered) |

## Verification
The state register chooses the outputs on the same edge that it changes. A wrong next-state decision therefore shows at the enables one clock after the input that caused it. That mistake appears either as an early turn-on without the feedback flag or as a missing turn-on after the flag.

A timer that is off by one, or that is not restarted, shows up as a low-side rise one or more cycles away from the 70th edge. An override placed on the wrong side of the output register shows up as a one-cycle lag or a one-cycle glitch on the first edge after the override changes.

// File: rtl/nol_pkg.sv
package nol_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_LOW_ON  = 3'd1,
    ST_WAIT_HS = 3'd2,
    ST_HS_ON   = 3'd3,
    ST_WAIT_LS = 3'd4
  } nol_state_e;

  localparam int unsigned TO_NS_MIN = 150;
  localparam int unsigned TO_NS_MAX = 600;

  function automatic int unsigned to_cycles(int unsigned ns, int unsigned period_ps);
    int unsigned eff;
    int unsigned cyc;
    eff = (ns < TO_NS_MIN) ? TO_NS_MIN : ((ns > TO_NS_MAX) ? TO_NS_MAX : ns);
    cyc = (eff * 1000) / period_ps;
    return (cyc < 1) ? 1 : cyc;
  endfunction
endpackage

// File: rtl/nol_timeout.sv
module nol_timeout #(
  parameter int unsigned TO_CYC = 70,
  localparam int unsigned CW    = $clog2(TO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LIMIT = CW'(TO_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (start_i)                  cnt_q <= CW'(1);
    else if (run_i && cnt_q != LIMIT)  cnt_q <= cnt_q + CW'(1);
    else if (!run_i)                   cnt_q <= '0;
  end

  assign expired_o = run_i && (cnt_q == LIMIT);
endmodule

// File: rtl/nol_fsm.sv
module nol_fsm
  import nol_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwm_i,
  input  logic       run_i,
  input  logic       crowbar_i,
  input  logic       sw_low_i,
  input  logic       hs_low_i,
  input  logic       ls_low_i,
  input  logic       expired_i,
  output nol_state_e state_q_o,
  output nol_state_e state_d_o,
  output logic       wait_enter_o
);
  nol_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (crowbar_i || !run_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     state_d = pwm_i ? ST_WAIT_HS : ST_WAIT_LS;
        ST_LOW_ON:  if (pwm_i) state_d = ST_WAIT_HS;
        ST_WAIT_HS: if (!pwm_i) state_d = ST_WAIT_LS;
                    else if (ls_low_i) state_d = ST_HS_ON;
        ST_HS_ON:   if (!pwm_i) state_d = ST_WAIT_LS;
        ST_WAIT_LS: if (pwm_i) state_d = ST_WAIT_HS;
                    else if ((sw_low_i && hs_low_i) || expired_i) state_d = ST_LOW_ON;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_q_o    = state_q;
  assign state_d_o    = state_d;
  assign wait_enter_o = (state_d == ST_WAIT_LS) && (state_q != ST_WAIT_LS);
endmodule

// File: rtl/nol_outstage.sv
module nol_outstage
  import nol_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  nol_state_e state_d_i,
  input  logic       run_i,
  input  logic       crowbar_i,
  input  logic       ls_dis_ni,
  output logic       hs_en_o,
  output logic       ls_en_o
);
  logic hs_d, ls_d, hs_q, ls_q;

  // crowbar outranks lockout, shutdown and low-side disable
  always_comb begin
    if (crowbar_i) begin
      hs_d = 1'b0;
      ls_d = 1'b1;
    end else if (!run_i) begin
      hs_d = 1'b0;
      ls_d = 1'b0;
    end else begin
      hs_d = (state_d_i == ST_HS_ON);
      ls_d = (state_d_i == ST_LOW_ON) && ls_dis_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_en_o = hs_q;
  assign ls_en_o = ls_q;
endmodule

// File: rtl/nol_gate_ctrl.sv
module nol_gate_ctrl
  import nol_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned TIMEOUT_NS    = 350,
  localparam int unsigned TO_CYC       = to_cycles(TIMEOUT_NS, CLK_PERIOD_PS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic shdn_ni,
  input  logic ls_dis_ni,
  input  logic crowbar_i,
  input  logic supply_ok_i,
  input  logic sw_low_i,
  input  logic hs_low_i,
  input  logic ls_low_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  nol_state_e state_q, state_d;
  logic       run, wait_enter, expired;

  assign run = supply_ok_i && shdn_ni;

  nol_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwm_i        (pwm_i),
    .run_i        (run),
    .crowbar_i    (crowbar_i),
    .sw_low_i     (sw_low_i),
    .hs_low_i     (hs_low_i),
    .ls_low_i     (ls_low_i),
    .expired_i    (expired),
    .state_q_o    (state_q),
    .state_d_o    (state_d),
    .wait_enter_o (wait_enter)
  );

  nol_timeout #(.TO_CYC(TO_CYC)) i_timeout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (wait_enter),
    .run_i     (state_q == ST_WAIT_LS),
    .expired_o (expired)
  );

  nol_outstage i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .run_i     (run),
    .crowbar_i (crowbar_i),
    .ls_dis_ni (ls_dis_ni),
    .hs_en_o   (hs_en_o),
    .ls_en_o   (ls_en_o)
  );
endmodule

// File: rtl/nol_gate_chk.sv
module nol_gate_chk #(
  parameter int unsigned TO_CYC = 70,
  localparam int unsigned CW    = $clog2(TO_CYC + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic shdn_ni,
  input logic ls_dis_ni,
  input logic crowbar_i,
  input logic supply_ok_i,
  input logic sw_low_i,
  input logic hs_low_i,
  input logic ls_low_i,
  input logic hs_en_o,
  input logic ls_en_o
);
  logic [CW-1:0] idle_q;
  logic          dis_q, dis_qq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      dis_q  <= 1'b1;
      dis_qq <= 1'b1;
    end else begin
      dis_q  <= ls_dis_ni;
      dis_qq <= dis_q;
      if (!hs_en_o && !ls_en_o && !pwm_i)
        idle_q <= (idle_q == CW'(TO_CYC)) ? idle_q : idle_q + CW'(1);
      else
        idle_q <= '0;
    end
  end

  // R1
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));
  // R2
  hs_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> $past(ls_low_i) && $past(pwm_i));
  // R2
  ls_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !crowbar_i) |=> !ls_en_o);
  // R3
  hs_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> !hs_en_o);
  // R4
  ls_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> $past(crowbar_i) || $past(sw_low_i && hs_low_i)
                       || !dis_qq || (idle_q == CW'(TO_CYC)));
  // R6
  shdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_ni && !crowbar_i) |=> !hs_en_o && !ls_en_o);
  // R7
  uvlo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok_i && !crowbar_i) |=> !hs_en_o && !ls_en_o);
  // R8
  lsdis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ls_dis_ni && !crowbar_i) |=> !ls_en_o);
  // R9
  crowbar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crowbar_i |=> !hs_en_o && ls_en_o);
endmodule

bind nol_gate_ctrl nol_gate_chk #(.TO_CYC(TO_CYC)) i_nol_gate_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwm_i       (pwm_i),
  .shdn_ni     (shdn_ni),
  .ls_dis_ni   (ls_dis_ni),
  .crowbar_i   (crowbar_i),
  .supply_ok_i (supply_ok_i),
  .sw_low_i    (sw_low_i),
  .hs_low_i    (hs_low_i),
  .ls_low_i    (ls_low_i),
  .hs_en_o     (hs_en_o),
  .ls_en_o     (ls_en_o)
);

// File: tb/test_nol_gate_ctrl.sv
module test_nol_gate_ctrl;
  localparam int unsigned PERIOD_PS = 5000;
  localparam int unsigned TO_NS     = 350;
  localparam int unsigned TO_EXP    = TO_NS * 1000 / PERIOD_PS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm, shdn_n, ls_dis_n, crowbar, sup_ok, sw_low, hs_low, ls_low;
  logic hs_en, ls_en;
  int   errors = 0;
  int   checks = 0;
  int   overlap = 0;
  bit   done = 1'b0;

  always #2.5ns clk = ~clk;

  nol_gate_ctrl #(.CLK_PERIOD_PS(PERIOD_PS), .TIMEOUT_NS(TO_NS)) i_nol_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .shdn_ni(shdn_n),
    .ls_dis_ni(ls_dis_n), .crowbar_i(crowbar), .supply_ok_i(sup_ok),
    .sw_low_i(sw_low), .hs_low_i(hs_low), .ls_low_i(ls_low),
    .hs_en_o(hs_en), .ls_en_o(ls_en)
  );

  always @(negedge clk) if (rst_ni && hs_en && ls_en) overlap++;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic hs_x, logic ls_x);
    checks++;
    if (hs_en !== hs_x || ls_en !== ls_x) begin
      errors++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b at %0t", req, hs_en, ls_en, hs_x, ls_x, $time);
    end
  endtask

  task automatic chk_val(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic flags(logic s, logic h, logic l);
    sw_low = s; hs_low = h; ls_low = l;
  endtask

  // edges from now until ls_en rises, capped
  task automatic count_ls(output int n);
    n = 0;
    while (!ls_en && n < 400) begin
      step(1);
      n++;
    end
  endtask

  initial begin
    int n;
    pwm = 0; shdn_n = 1; ls_dis_n = 1; crowbar = 0; sup_ok = 1;
    flags(1, 1, 1);
    step(2);
    chk("R10 reset", 0, 0);
    rst_ni = 1'b1;
    step(1);
    chk("R10 first edge", 0, 0);

    // sweep of the five control inputs, flags idealized true
    for (int c = 0; c < 32; c++) begin
      logic ep, es, ed, ec, eu, ehs, els;
      ep = c[0]; es = c[1]; ed = c[2]; ec = c[3]; eu = c[4];
      pwm = ep; shdn_n = es; ls_dis_n = ed; crowbar = ec; sup_ok = eu;
      step(1);
      if (ec)              chk("R9 sweep next edge", 0, 1);
      else if (!eu)        chk("R7 sweep next edge", 0, 0);
      else if (!es)        chk("R6 sweep next edge", 0, 0);
      else if (!ed)        begin checks++; if (ls_en !== 0) begin errors++; $display("FAIL R8 sweep: ls=%b expected 0", ls_en); end end
      step(2);
      ehs = !ec && eu && es && ep;
      els = ec || (eu && es && !ep && ed);
      chk(ec ? "R9 sweep" : (ep ? "R2 sweep" : "R3 R8 sweep"), ehs, els);
    end

    // R2: high-side waits for low-side-drive-low flag
    pwm = 0; shdn_n = 1; ls_dis_n = 1; crowbar = 0; sup_ok = 1; flags(1, 1, 1);
    step(3);
    chk("R2 start low", 0, 1);
    flags(0, 0, 0);
    pwm = 1;
    step(1);
    chk("R2 ls drop", 0, 0);
    step(6);
    chk("R2 hs held", 0, 0);
    ls_low = 1;
    step(1);
    chk("R2 hs on", 1, 0);

    // R3: needs both flags
    ls_low = 0; pwm = 0;
    step(1);
    chk("R3 hs drop", 0, 0);
    hs_low = 1;
    step(5);
    chk("R3 one flag", 0, 0);
    sw_low = 1;
    step(1);
    chk("R3 ls on", 0, 1);

    // R4: timeout count
    flags(0, 0, 1); pwm = 1;
    step(3);
    chk("R4 setup hs", 1, 0);
    ls_low = 0; pwm = 0;
    step(1);
    chk("R4 hs drop", 0, 0);
    count_ls(n);
    chk_val("R4 timeout edges", n, TO_EXP);

    // R5: re-rise cancels, next fall restarts
    ls_low = 1; pwm = 1;
    step(3);
    ls_low = 0; pwm = 0;
    step(40);
    chk("R5 mid wait", 0, 0);
    ls_low = 1; pwm = 1;
    step(2);
    chk("R5 hs back", 1, 0);
    ls_low = 0; pwm = 0;
    step(1);
    count_ls(n);
    chk_val("R5 restarted count", n, TO_EXP);

    // R8: hs unaffected by low-side disable
    ls_low = 1; pwm = 1; ls_dis_n = 0;
    step(3);
    chk("R8 hs unaffected", 1, 0);
    pwm = 0; flags(1, 1, 1);
    step(3);
    chk("R8 ls held", 0, 0);
    ls_dis_n = 1;
    step(1);
    chk("R8 release", 0, 1);

    // R6: release goes back through wait
    shdn_n = 0;
    step(2);
    flags(0, 0, 1);
    shdn_n = 1;
    step(5);
    chk("R6 release waits", 0, 0);
    flags(1, 1, 1);
    step(1);
    chk("R6 ls after flags", 0, 1);

    // R9 overrides everything at once
    pwm = 1; shdn_n = 0; sup_ok = 0; ls_dis_n = 0; crowbar = 1; flags(0, 0, 0);
    step(1);
    chk("R9 all overrides", 0, 1);
    crowbar = 0;
    step(1);
    chk("R7 after crowbar", 0, 0);

    chk_val("R1 overlap cycles", overlap, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule